// File: doc/BRIEF.md
# Reorder Buffer with Inline Exception Handler

This block is the in-order retirement queue of an out-of-order core. Instructions enter at the tail in program order and receive a slot tag. Writeback later marks a slot complete, and can also mark it as having raised an exception. Retirement runs from the head at one entry per cycle. An exception is only acted upon once the faulting entry is the oldest entry and has completed. Every slot stores a privilege bit, so user code and privileged handler code can be in flight together.

When a completed, flagged entry reaches the head, the buffer reports the exception and that entry's PC. A separate controller then chooses one of two actions:
- **Discard:** drop the whole window.
- **Inline:** keep every live entry and accept a handler of a stated length, appended behind the existing tail.

Inlined handler entries retire ahead of the blocked head. When the last of them has retired, the faulting entry is left unflagged and waits for a fresh writeback from its re-execution. If the handler does not fit in the free slots, or if a second exception arrives while a handler is inlined, the buffer discards everything instead.

Top module: `rob_inline`

## Requirements
- R1: After reset the buffer is empty: free count equals DEPTH, allocation is ready, and no retirement, exception report or inline mode is shown.
- R2: Accepted allocations receive consecutive slot tags modulo DEPTH in program order. The free count always equals DEPTH minus the number of slots between head and tail. Allocation is refused while the free count is zero.
- R3: An entry retires only when it is the oldest entry, has been written back and carries no exception flag. Entries written back in any order retire in allocation order, and each retirement reports the entry's PC and privilege bit (0 for user entries).
- R4: While the oldest entry is complete and flagged, and no handler is inlined, the exception output is high with that entry's PC, and no entry retires.
- R5: A discard command given while the exception is reported empties the buffer at the next edge. An allocation or a writeback presented in that same cycle is refused or lost.
- R6: An inline command with a length from 1 up to the free count keeps every entry: the free count is unchanged one cycle later and the inline indication rises. While inlined, only privileged allocations are accepted, and at most the given length of them.
- R7: Inlined handler entries retire in order with privilege bit 1 while the head stays blocked. After the given number of handler retirements, inline mode ends and the former faulting entry is left unflagged and not complete. It retires only after a new writeback, followed by the younger user entries.
- R8: An inline command whose length is zero or exceeds the free count is handled as a discard.
- R9: A writeback carrying an exception while a handler is inlined empties the buffer at the next edge and ends inline mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_pc_i | input | PC_W | PC of the allocated instruction |
| alloc_priv_i | input | 1 | Privilege bit of the allocated instruction (1 = handler) |
| alloc_ready_o | output | 1 | Allocation accepted this cycle if requested |
| alloc_tag_o | output | log2(DEPTH) | Slot tag given to the allocation |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_tag_i | input | log2(DEPTH) | Slot being written back |
| wb_exc_i | input | 1 | Writeback carries an exception |
| commit_valid_o | output | 1 | An entry retires at this edge |
| commit_pc_o | output | PC_W | PC of the retiring entry |
| commit_priv_o | output | 1 | Privilege bit of the retiring entry |
| exc_valid_o | output | 1 | Flagged head entry awaiting a decision |
| exc_pc_o | output | PC_W | PC of the flagged head entry |
| cmd_flush_i | input | 1 | Controller selects discard |
| cmd_inline_i | input | 1 | Controller selects inline |
| inline_len_i | input | LEN_W | Number of handler entries for inline |
| inline_o | output | 1 | Handler is inlined |
| free_o | output | log2(DEPTH)+1 | Free slot count |

## Verification
The bench builds the buffer with DEPTH=4, PC_W=16 and LEN_W=3. Four slots let a few allocations fill the buffer and wrap the pointers, so the full-refusal path and tag wrap are reached within every table row. A 3-bit handler length can exceed the depth, which exercises the no-room fallback to discard. Writeback permutations check in-order retirement, and directed sequences cover inline retirement, replay of the faulting entry and the second-exception discard.

// File: rtl/rob_inline_pkg.sv
package rob_inline_pkg;

    // Per-slot status bits
    typedef struct packed {
        logic valid;
        logic done;
        logic exc;
        logic priv;
    } rob_flags_t;

    // Action resolved for a flagged head entry
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_FLUSH  = 2'd1,
        ACT_INLINE = 2'd2
    } exc_act_e;

endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_inline_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             alloc_en_i,
    input  logic [IDX_W-1:0] alloc_idx_i,
    input  logic [PC_W-1:0]  alloc_pc_i,
    input  logic             alloc_priv_i,
    input  logic             wb_en_i,
    input  logic [IDX_W-1:0] wb_idx_i,
    input  logic             wb_exc_i,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    input  logic             replay_en_i,
    input  logic [IDX_W-1:0] replay_idx_i,
    input  logic [IDX_W-1:0] head_idx_i,
    input  logic [IDX_W-1:0] hptr_idx_i,
    output rob_flags_t       head_flags_o,
    output logic [PC_W-1:0]  head_pc_o,
    output rob_flags_t       hptr_flags_o,
    output logic [PC_W-1:0]  hptr_pc_o
);

    rob_flags_t      flags_w [DEPTH];
    logic [PC_W-1:0] pc_w    [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rob_flags_t      f_d, f_q;
        logic [PC_W-1:0] pc_d, pc_q;

        always_comb begin
            f_d  = f_q;
            pc_d = pc_q;
            if (wb_en_i && wb_idx_i == IDX_W'(g) && f_q.valid) begin
                f_d.done = 1'b1;
                f_d.exc  = wb_exc_i;
            end
            if (replay_en_i && replay_idx_i == IDX_W'(g)) begin
                f_d.done = 1'b0;
                f_d.exc  = 1'b0;
            end
            if (clr_en_i && clr_idx_i == IDX_W'(g)) begin
                f_d.valid = 1'b0;
            end
            if (alloc_en_i && alloc_idx_i == IDX_W'(g)) begin
                f_d.valid = 1'b1;
                f_d.done  = 1'b0;
                f_d.exc   = 1'b0;
                f_d.priv  = alloc_priv_i;
                pc_d      = alloc_pc_i;
            end
            if (flush_i) begin
                f_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q  <= '0;
                pc_q <= '0;
            end else begin
                f_q  <= f_d;
                pc_q <= pc_d;
            end
        end

        assign flags_w[g] = f_q;
        assign pc_w[g]    = pc_q;
    end

    assign head_flags_o = flags_w[head_idx_i];
    assign head_pc_o    = pc_w[head_idx_i];
    assign hptr_flags_o = flags_w[hptr_idx_i];
    assign hptr_pc_o    = pc_w[hptr_idx_i];

endmodule

// File: rtl/rob_inline_ctrl.sv
module rob_inline_ctrl
    import rob_inline_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid_i,
    input  logic             alloc_priv_i,
    input  logic             wb_valid_i,
    input  logic             wb_exc_i,
    input  logic             cmd_flush_i,
    input  logic             cmd_inline_i,
    input  logic [LEN_W-1:0] inline_len_i,
    input  logic             head_valid_i,
    input  logic             head_done_i,
    input  logic             head_exc_i,
    input  logic             hptr_valid_i,
    input  logic             hptr_done_i,
    input  logic             hptr_exc_i,
    output logic             alloc_ready_o,
    output logic             alloc_fire_o,
    output logic [IDX_W-1:0] tail_idx_o,
    output logic [IDX_W-1:0] head_idx_o,
    output logic [IDX_W-1:0] hptr_idx_o,
    output logic             commit_valid_o,
    output logic             commit_hdl_o,
    output logic             exc_valid_o,
    output logic             flush_o,
    output logic             replay_o,
    output logic             wb_en_o,
    output logic             inline_o,
    output logic [PTR_W-1:0] free_o
);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [PTR_W-1:0] hptr;
        logic             inl;
        logic [LEN_W-1:0] hc_rem;
        logic [LEN_W-1:0] ha_rem;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    exc_act_e         act;
    logic [PTR_W-1:0] occ, free;
    logic             full, empty, head_live, exc_v, fits, wb_flush, flush;
    logic             alloc_ok, alloc_fire, commit_norm, commit_hdl, skip;

    always_comb begin
        occ       = st_q.tail - st_q.head;
        free      = PTR_W'(DEPTH) - occ;
        full      = (occ == PTR_W'(DEPTH));
        empty     = (occ == '0);
        head_live = !empty && head_valid_i;
        exc_v     = !st_q.inl && head_live && head_done_i && head_exc_i;
        fits      = (inline_len_i != '0) && (32'(inline_len_i) <= 32'(free));

        act = ACT_NONE;
        if (exc_v && cmd_flush_i) begin
            act = ACT_FLUSH;
        end else if (exc_v && cmd_inline_i) begin
            act = fits ? ACT_INLINE : ACT_FLUSH;
        end

        wb_flush = st_q.inl && wb_valid_i && wb_exc_i;
        flush    = (act == ACT_FLUSH) || wb_flush;

        alloc_ok = !full && (act == ACT_NONE) && !wb_flush &&
                   (!st_q.inl || (alloc_priv_i && st_q.ha_rem != '0));
        alloc_fire = alloc_valid_i && alloc_ok;

        commit_norm = !st_q.inl && head_live && head_done_i && !head_exc_i;
        commit_hdl  = st_q.inl && !wb_flush && (st_q.hptr != st_q.tail) &&
                      hptr_valid_i && hptr_done_i && !hptr_exc_i;
        skip        = !st_q.inl && !empty && !head_valid_i;

        st_d = st_q;
        if (alloc_fire) begin
            st_d.tail = st_q.tail + PTR_W'(1);
            if (st_q.inl) begin
                st_d.ha_rem = st_q.ha_rem - LEN_W'(1);
            end
        end
        if (commit_norm || skip) begin
            st_d.head = st_q.head + PTR_W'(1);
        end
        if (commit_hdl) begin
            st_d.hptr   = st_q.hptr + PTR_W'(1);
            st_d.hc_rem = st_q.hc_rem - LEN_W'(1);
            if (st_q.hc_rem == LEN_W'(1)) begin
                st_d.inl = 1'b0;
            end
        end
        if (act == ACT_INLINE) begin
            st_d.inl    = 1'b1;
            st_d.hptr   = st_q.tail;
            st_d.hc_rem = inline_len_i;
            st_d.ha_rem = inline_len_i;
        end
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_ready_o  = alloc_ok;
    assign alloc_fire_o   = alloc_fire;
    assign tail_idx_o     = st_q.tail[IDX_W-1:0];
    assign head_idx_o     = st_q.head[IDX_W-1:0];
    assign hptr_idx_o     = st_q.hptr[IDX_W-1:0];
    assign commit_valid_o = commit_norm || commit_hdl;
    assign commit_hdl_o   = commit_hdl;
    assign exc_valid_o    = exc_v;
    assign flush_o        = flush;
    assign replay_o       = (act == ACT_INLINE);
    assign wb_en_o        = wb_valid_i && !flush;
    assign inline_o       = st_q.inl;
    assign free_o         = free;

endmodule

// File: rtl/rob_inline.sv
module rob_inline
    import rob_inline_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    parameter int LEN_W = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid_i,
    input  logic [PC_W-1:0]  alloc_pc_i,
    input  logic             alloc_priv_i,
    output logic             alloc_ready_o,
    output logic [IDX_W-1:0] alloc_tag_o,
    input  logic             wb_valid_i,
    input  logic [IDX_W-1:0] wb_tag_i,
    input  logic             wb_exc_i,
    output logic             commit_valid_o,
    output logic [PC_W-1:0]  commit_pc_o,
    output logic             commit_priv_o,
    output logic             exc_valid_o,
    output logic [PC_W-1:0]  exc_pc_o,
    input  logic             cmd_flush_i,
    input  logic             cmd_inline_i,
    input  logic [LEN_W-1:0] inline_len_i,
    output logic             inline_o,
    output logic [PTR_W-1:0] free_o
);

    rob_flags_t       head_flags, hptr_flags;
    logic [PC_W-1:0]  head_pc, hptr_pc;
    logic [IDX_W-1:0] tail_idx, head_idx, hptr_idx, clr_idx;
    logic             alloc_fire, commit_v, commit_hdl, flush, replay, wb_en;

    rob_inline_ctrl #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W)
    ) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid_i  (alloc_valid_i),
        .alloc_priv_i   (alloc_priv_i),
        .wb_valid_i     (wb_valid_i),
        .wb_exc_i       (wb_exc_i),
        .cmd_flush_i    (cmd_flush_i),
        .cmd_inline_i   (cmd_inline_i),
        .inline_len_i   (inline_len_i),
        .head_valid_i   (head_flags.valid),
        .head_done_i    (head_flags.done),
        .head_exc_i     (head_flags.exc),
        .hptr_valid_i   (hptr_flags.valid),
        .hptr_done_i    (hptr_flags.done),
        .hptr_exc_i     (hptr_flags.exc),
        .alloc_ready_o  (alloc_ready_o),
        .alloc_fire_o   (alloc_fire),
        .tail_idx_o     (tail_idx),
        .head_idx_o     (head_idx),
        .hptr_idx_o     (hptr_idx),
        .commit_valid_o (commit_v),
        .commit_hdl_o   (commit_hdl),
        .exc_valid_o    (exc_valid_o),
        .flush_o        (flush),
        .replay_o       (replay),
        .wb_en_o        (wb_en),
        .inline_o       (inline_o),
        .free_o         (free_o)
    );

    assign clr_idx = commit_hdl ? hptr_idx : head_idx;

    rob_entry_array #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W)
    ) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .alloc_en_i   (alloc_fire),
        .alloc_idx_i  (tail_idx),
        .alloc_pc_i   (alloc_pc_i),
        .alloc_priv_i (alloc_priv_i),
        .wb_en_i      (wb_en),
        .wb_idx_i     (wb_tag_i),
        .wb_exc_i     (wb_exc_i),
        .clr_en_i     (commit_v),
        .clr_idx_i    (clr_idx),
        .replay_en_i  (replay),
        .replay_idx_i (head_idx),
        .head_idx_i   (head_idx),
        .hptr_idx_i   (hptr_idx),
        .head_flags_o (head_flags),
        .head_pc_o    (head_pc),
        .hptr_flags_o (hptr_flags),
        .hptr_pc_o    (hptr_pc)
    );

    assign alloc_tag_o    = tail_idx;
    assign commit_valid_o = commit_v;
    assign commit_pc_o    = commit_hdl ? hptr_pc : head_pc;
    assign commit_priv_o  = commit_hdl ? hptr_flags.priv : head_flags.priv;
    assign exc_pc_o       = head_pc;

endmodule

// File: rtl/rob_inline_chk.sv
module rob_inline_chk #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    parameter int LEN_W = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid_i,
    input logic [PC_W-1:0]  alloc_pc_i,
    input logic             alloc_priv_i,
    input logic             alloc_ready_o,
    input logic [IDX_W-1:0] alloc_tag_o,
    input logic             wb_valid_i,
    input logic [IDX_W-1:0] wb_tag_i,
    input logic             wb_exc_i,
    input logic             commit_valid_o,
    input logic [PC_W-1:0]  commit_pc_o,
    input logic             commit_priv_o,
    input logic             exc_valid_o,
    input logic [PC_W-1:0]  exc_pc_o,
    input logic             cmd_flush_i,
    input logic             cmd_inline_i,
    input logic [LEN_W-1:0] inline_len_i,
    input logic             inline_o,
    input logic [PTR_W-1:0] free_o
);

    p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o == '0) |-> !alloc_ready_o);

    p_free_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(free_o) <= 32'(DEPTH));

    p_exc_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> !commit_valid_o);

    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_o && cmd_flush_i) |=>
        (free_o == PTR_W'(DEPTH)) && !exc_valid_o && !inline_o);

    p_inline_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_o && cmd_inline_i && !cmd_flush_i && inline_len_i != '0 &&
         32'(inline_len_i) <= 32'(free_o)) |=>
        inline_o && (free_o == $past(free_o)));

    p_inline_user_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inline_o && !alloc_priv_i) |-> !alloc_ready_o);

    p_inline_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inline_o && commit_valid_o) |-> commit_priv_o);

    p_short_room_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_o && cmd_inline_i &&
         (inline_len_i == '0 || 32'(inline_len_i) > 32'(free_o))) |=>
        (free_o == PTR_W'(DEPTH)) && !inline_o);

    p_second_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inline_o && wb_valid_i && wb_exc_i) |=>
        (free_o == PTR_W'(DEPTH)) && !inline_o);

endmodule

bind rob_inline rob_inline_chk #(
    .DEPTH (DEPTH),
    .PC_W  (PC_W),
    .LEN_W (LEN_W)
) chk_i (.*);

// File: tb/rob_inline_tb_top.sv
`timescale 1ns/1ps
module rob_inline_tb_top;

    localparam int DEPTH = 4;
    localparam int PC_W  = 16;
    localparam int LEN_W = 3;
    localparam int IDX_W = 2;
    localparam int PTR_W = 3;

    // Writeback orders: slot k of a row holds the entry index written back k-th
    localparam logic [7:0] PERM_TAB [4] = '{8'b11_10_01_00, 8'b00_01_10_11,
                                            8'b10_00_11_01, 8'b01_11_00_10};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic             alloc_valid_i, alloc_priv_i, alloc_ready_o;
    logic [PC_W-1:0]  alloc_pc_i;
    logic [IDX_W-1:0] alloc_tag_o, wb_tag_i;
    logic             wb_valid_i, wb_exc_i;
    logic             commit_valid_o, commit_priv_o, exc_valid_o;
    logic [PC_W-1:0]  commit_pc_o, exc_pc_o;
    logic             cmd_flush_i, cmd_inline_i, inline_o;
    logic [LEN_W-1:0] inline_len_i;
    logic [PTR_W-1:0] free_o;

    rob_inline #(.DEPTH(DEPTH), .PC_W(PC_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_pc_i(alloc_pc_i),
        .alloc_priv_i(alloc_priv_i), .alloc_ready_o(alloc_ready_o),
        .alloc_tag_o(alloc_tag_o),
        .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_exc_i(wb_exc_i),
        .commit_valid_o(commit_valid_o), .commit_pc_o(commit_pc_o),
        .commit_priv_o(commit_priv_o),
        .exc_valid_o(exc_valid_o), .exc_pc_o(exc_pc_o),
        .cmd_flush_i(cmd_flush_i), .cmd_inline_i(cmd_inline_i),
        .inline_len_i(inline_len_i), .inline_o(inline_o), .free_o(free_o)
    );

    int total = 0;
    int bad   = 0;

    logic [PC_W-1:0] log_pc   [256];
    logic            log_priv [256];
    int              nlog = 0;

    // Retirement monitor, sampled 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n && commit_valid_o && nlog < 256) begin
            log_pc[nlog]   = commit_pc_o;
            log_priv[nlog] = commit_priv_o;
            nlog++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        alloc_valid_i = 1'b0; alloc_pc_i = '0; alloc_priv_i = 1'b0;
        wb_valid_i = 1'b0; wb_tag_i = '0; wb_exc_i = 1'b0;
        cmd_flush_i = 1'b0; cmd_inline_i = 1'b0; inline_len_i = '0;
    endtask

    task automatic do_alloc(input logic [PC_W-1:0] pc, input logic priv,
                            output logic ok, output logic [IDX_W-1:0] tag);
        @(negedge clk);
        clear_in();
        alloc_valid_i = 1'b1; alloc_pc_i = pc; alloc_priv_i = priv;
        #1;
        ok  = alloc_ready_o;
        tag = alloc_tag_o;
    endtask

    task automatic do_wb(input logic [IDX_W-1:0] tag, input logic exc);
        @(negedge clk);
        clear_in();
        wb_valid_i = 1'b1; wb_tag_i = tag; wb_exc_i = exc;
        #1;
    endtask

    task automatic do_cmd(input logic fl, input logic il, input logic [LEN_W-1:0] len);
        @(negedge clk);
        clear_in();
        cmd_flush_i = fl; cmd_inline_i = il; inline_len_i = len;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            clear_in();
        end
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic             ok;
        logic [IDX_W-1:0] tg;
        logic [IDX_W-1:0] tags [4];
        int               base;
        int               tag_ctr;

        rst_n = 1'b0;
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 free", int'(free_o), DEPTH);
        chk("R1 ready", int'(alloc_ready_o), 1);
        chk("R1 commit", int'(commit_valid_o), 0);
        chk("R1 exc", int'(exc_valid_o), 0);
        chk("R1 inline", int'(inline_o), 0);

        // Table walk: R2 allocation order, R3 in-order retirement
        tag_ctr = 0;
        for (int r = 0; r < 4; r++) begin
            base = nlog;
            for (int i = 0; i < 4; i++) begin
                do_alloc(16'(16'h100 * (r + 1) + i), 1'b0, ok, tg);
                chk("R2 alloc accepted", int'(ok), 1);
                chk("R2 tag order", int'(tg), tag_ctr % DEPTH);
                tags[i] = tg;
                tag_ctr++;
            end
            idle(1);
            chk("R2 free when full", int'(free_o), 0);
            chk("R2 refused when full", int'(alloc_ready_o), 0);
            for (int k = 0; k < 4; k++) begin
                do_wb(tags[PERM_TAB[r][2*k +: 2]], 1'b0);
            end
            idle(8);
            chk("R3 retire count", nlog - base, 4);
            for (int i = 0; i < 4; i++) begin
                chk("R3 retire pc order", int'(log_pc[base + i]), 16'h100 * (r + 1) + i);
                chk("R3 retire priv", int'(log_priv[base + i]), 0);
            end
            chk("R2 free after drain", int'(free_o), DEPTH);
        end

        // R4 flagged head, R5 discard with same-cycle alloc and writeback
        do_alloc(16'h500, 1'b0, ok, tags[0]);
        do_alloc(16'h501, 1'b0, ok, tags[1]);
        do_alloc(16'h502, 1'b0, ok, tags[2]);
        do_wb(tags[0], 1'b1);
        do_wb(tags[1], 1'b0);
        do_wb(tags[2], 1'b0);
        idle(1);
        chk("R4 exc reported", int'(exc_valid_o), 1);
        chk("R4 exc pc", int'(exc_pc_o), 16'h500);
        chk("R4 no retire", int'(commit_valid_o), 0);
        base = nlog;
        idle(3);
        chk("R4 younger blocked", nlog - base, 0);
        @(negedge clk);
        clear_in();
        cmd_flush_i = 1'b1;
        alloc_valid_i = 1'b1; alloc_pc_i = 16'h5ff;
        wb_valid_i = 1'b1; wb_tag_i = tags[1];
        #1;
        chk("R5 alloc refused on discard", int'(alloc_ready_o), 0);
        idle(1);
        chk("R5 emptied", int'(free_o), DEPTH);
        chk("R5 exc cleared", int'(exc_valid_o), 0);
        chk("R5 nothing retired", nlog - base, 0);

        // R6 inline acceptance, R7 handler retirement and replay
        do_alloc(16'h600, 1'b0, ok, tags[0]);
        do_alloc(16'h601, 1'b0, ok, tags[1]);
        do_wb(tags[1], 1'b0);
        do_wb(tags[0], 1'b1);
        idle(1);
        chk("R4 exc before inline", int'(exc_valid_o), 1);
        do_cmd(1'b0, 1'b1, 3'd2);
        idle(1);
        chk("R6 inline on", int'(inline_o), 1);
        chk("R6 entries kept", int'(free_o), 2);
        chk("R6 exc withdrawn", int'(exc_valid_o), 0);
        do_alloc(16'h6ff, 1'b0, ok, tg);
        chk("R6 user alloc refused", int'(ok), 0);
        do_alloc(16'h700, 1'b1, ok, tags[2]);
        chk("R6 handler alloc 0", int'(ok), 1);
        do_alloc(16'h701, 1'b1, ok, tags[3]);
        chk("R6 handler alloc 1", int'(ok), 1);
        do_alloc(16'h702, 1'b1, ok, tg);
        chk("R6 handler alloc beyond length", int'(ok), 0);
        base = nlog;
        do_wb(tags[3], 1'b0);
        do_wb(tags[2], 1'b0);
        idle(4);
        chk("R7 handler retire count", nlog - base, 2);
        chk("R7 handler pc 0", int'(log_pc[base]), 16'h700);
        chk("R7 handler pc 1", int'(log_pc[base + 1]), 16'h701);
        chk("R7 handler priv 0", int'(log_priv[base]), 1);
        chk("R7 handler priv 1", int'(log_priv[base + 1]), 1);
        chk("R7 inline ended", int'(inline_o), 0);
        chk("R7 flag cleared", int'(exc_valid_o), 0);
        chk("R7 replay waits", nlog - base, 2);
        do_wb(tags[0], 1'b0);
        idle(8);
        chk("R7 replay retire count", nlog - base, 4);
        chk("R7 replay pc", int'(log_pc[base + 2]), 16'h600);
        chk("R7 replay priv", int'(log_priv[base + 2]), 0);
        chk("R7 younger user pc", int'(log_pc[base + 3]), 16'h601);
        chk("R7 drained", int'(free_o), DEPTH);

        // R8 inline without room, then zero length
        do_alloc(16'h800, 1'b0, ok, tags[0]);
        do_alloc(16'h801, 1'b0, ok, tags[1]);
        do_alloc(16'h802, 1'b0, ok, tags[2]);
        do_wb(tags[0], 1'b1);
        idle(1);
        do_cmd(1'b0, 1'b1, 3'd2);
        idle(1);
        chk("R8 no room discards", int'(free_o), DEPTH);
        chk("R8 no room no inline", int'(inline_o), 0);
        do_alloc(16'h810, 1'b0, ok, tags[0]);
        do_wb(tags[0], 1'b1);
        idle(1);
        do_cmd(1'b0, 1'b1, 3'd0);
        idle(1);
        chk("R8 zero length discards", int'(free_o), DEPTH);
        chk("R8 zero length no inline", int'(inline_o), 0);

        // R9 second exception while inlined
        do_alloc(16'h900, 1'b0, ok, tags[0]);
        do_alloc(16'h901, 1'b0, ok, tags[1]);
        do_wb(tags[0], 1'b1);
        idle(1);
        do_cmd(1'b0, 1'b1, 3'd1);
        idle(1);
        chk("R9 inline on", int'(inline_o), 1);
        do_alloc(16'h980, 1'b1, ok, tags[2]);
        chk("R9 handler accepted", int'(ok), 1);
        do_wb(tags[1], 1'b1);
        idle(1);
        chk("R9 discard on second exc", int'(free_o), DEPTH);
        chk("R9 inline off", int'(inline_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule